// File: doc/BRIEF.md
# Virtual Address Segment Decoder and Fault Classifier

This block sits at the front of a memory management unit for a 32-bit processor with a fixed segment map. Each cycle it takes a virtual address, the access direction and the privilege state. It decides which architectural segment the address falls in. The two kernel direct-mapped windows are translated by subtracting a constant base. The user window, when the error-level flag is set, passes straight through. All other segments raise a lookup request towards an external translation lookaside buffer, whose result comes back in the same cycle.

When the access cannot complete, the block raises a fault flag and an exception kind. The kinds are: an address error for a user access to kernel space, a TLB load or store exception, or a modified-page exception for a write to a clean page. A separate refill indication marks the case where no entry matched at all. A matched entry that is not valid leaves the refill indication clear.

On a clock edge where a fault is flagged and the capture enable is high, three fault-capture registers are written from the faulting address:
- the bad virtual address;
- a context word, which combines an externally held page-table base with the virtual page-pair number;
- an entry-high word, which combines the virtual page number with the current address-space identifier.

Top module: `vseg_xlate_unit`

## Requirements
- R1: When user_mode_i is 1 and va_i[31] is 1, fault_o is 1, refill_o is 0 and tlb_req_o is 0. exc_o is 1 (load address error) when is_store_i is 0, and 2 (store address error) when is_store_i is 1. The TLB inputs have no effect in this case.
- R2: When va_i is below 0x80000000 and err_level_i is 1, pa_o equals va_i, perm_rd_o and perm_wr_o are both 1, tlb_req_o is 0, fault_o is 0 and exc_o is 0 (none).
- R3: When va_i is below 0x80000000 and err_level_i is 0, tlb_req_o is 1 and the outcome follows the TLB inputs as described in R7 to R9.
- R4: For a non-faulting access in 0x80000000 to 0x9FFFFFFF, pa_o is va_i minus 0x80000000, both permissions are 1, fault_o is 0 and tlb_req_o is 0.
- R5: For a non-faulting access in 0xA0000000 to 0xBFFFFFFF, pa_o is va_i minus 0xA0000000, both permissions are 1, fault_o is 0 and tlb_req_o is 0.
- R6: For a non-faulting access at 0xC0000000 or above (user_mode_i 0), tlb_req_o is 1, whatever the value of err_level_i.
- R7: When a lookup is requested and tlb_hit_i is 0, fault_o is 1 and refill_o is 1. exc_o is 3 (TLB load) for a load and 4 (TLB store) for a store.
- R8: When a lookup is requested, tlb_hit_i is 1 and tlb_valid_i is 0, fault_o is 1 and refill_o is 0. exc_o is 3 for a load and 4 for a store.
- R9: When a lookup hits a valid entry, a store with tlb_dirty_i 0 faults with exc_o 5 (modified) and refill_o 0. Any other such access has fault_o 0, pa_o equal to tlb_pa_i, perm_rd_o 1 and perm_wr_o equal to tlb_dirty_i. Whenever fault_o is 1, pa_o and both permissions are 0.
- R10: On a rising clock edge with fault_o and cap_en_i both 1, badva_o takes va_i.
- R11: On the same capture edge, context_o takes {ptebase_i, va_i[31:13], 4'b0000}. entryhi_o takes {va_i[31:12], 4'b0000, asid_i}.
- R12: After reset, badva_o, context_o and entryhi_o are 0. On any edge without a capture, all three keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_i | input | 32 | Virtual address |
| is_store_i | input | 1 | 1 for a write access, 0 for a read |
| user_mode_i | input | 1 | Access made in user mode |
| err_level_i | input | 1 | Error-level flag; bypasses mapping of the user window |
| tlb_hit_i | input | 1 | TLB found a matching entry |
| tlb_valid_i | input | 1 | Matched entry is valid |
| tlb_dirty_i | input | 1 | Matched entry allows writes |
| tlb_pa_i | input | 32 | Physical address from the TLB |
| cap_en_i | input | 1 | Allows fault capture on this edge |
| asid_i | input | 8 | Current address-space identifier |
| ptebase_i | input | 9 | Current page-table base field of the context word |
| tlb_req_o | output | 1 | Address needs a TLB lookup |
| pa_o | output | 32 | Physical address |
| perm_rd_o | output | 1 | Read permitted |
| perm_wr_o | output | 1 | Write permitted |
| fault_o | output | 1 | Access faults |
| exc_o | output | 3 | Exception kind: 0 none, 1 load address error, 2 store address error, 3 TLB load, 4 TLB store, 5 modified |
| refill_o | output | 1 | Fault is a TLB no-match (refill) |
| badva_o | output | 32 | Captured bad virtual address |
| context_o | output | 32 | Captured context word |
| entryhi_o | output | 32 | Captured entry-high word |

## Verification
The bench builds the block with its default widths: a 32-bit address, an 8-bit identifier and a 9-bit page-table base. With these widths, every control combination can be swept exhaustively: direction, user mode, error level, all eight TLB result patterns, and capture enabled or disabled. This sweep is crossed with all eight 512 MB regions of the address space. Within each region the bench uses the lowest address, the highest address and a mixed interior address, so every segment boundary is seen on both sides. Expected translations, exception kinds and captured register words are computed arithmetically from the address ranges.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    localparam int VA_W     = 32;
    localparam int PAGE_SH  = 12;
    localparam int PAIR_SH  = PAGE_SH + 1;
    localparam int CTX_PAD  = 4;
    localparam int EXC_W    = 3;

    localparam logic [VA_W-1:0] K0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] K1_BASE = 32'hA000_0000;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE = 3'd0,
        EXC_ADEL = 3'd1,
        EXC_ADES = 3'd2,
        EXC_TLBL = 3'd3,
        EXC_TLBS = 3'd4,
        EXC_MOD  = 3'd5
    } exc_e;

    typedef enum logic [2:0] {
        SEG_USER = 3'd0,
        SEG_K0   = 3'd1,
        SEG_K1   = 3'd2,
        SEG_K2   = 3'd3,
        SEG_K3   = 3'd4
    } seg_e;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        logic            rd;
        logic            wr;
    } xlate_t;

    typedef struct packed {
        logic hit;
        logic valid;
        logic dirty;
    } tlb_res_t;

    function automatic seg_e seg_of(input logic [VA_W-1:0] va);
        seg_e s;
        case (va[VA_W-1 -: 3])
            3'd4:    s = SEG_K0;
            3'd5:    s = SEG_K1;
            3'd6:    s = SEG_K2;
            3'd7:    s = SEG_K3;
            default: s = SEG_USER;
        endcase
        return s;
    endfunction

    function automatic exc_e pick_exc(input logic store,
                                      input exc_e on_load,
                                      input exc_e on_store);
        return store ? on_store : on_load;
    endfunction

endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
    import vseg_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            user_mode,
    input  logic            err_level,
    output seg_e            seg,
    output logic            adr_err,
    output logic            need_tlb,
    output xlate_t          fixed
);
    always_comb begin
        seg      = seg_of(va);
        adr_err  = user_mode && (seg != SEG_USER);
        need_tlb = 1'b0;
        fixed    = '0;
        if (!adr_err) begin
            case (seg)
                SEG_USER: begin
                    if (err_level) begin
                        fixed.pa = va;
                        fixed.rd = 1'b1;
                        fixed.wr = 1'b1;
                    end else begin
                        need_tlb = 1'b1;
                    end
                end
                SEG_K0: begin
                    fixed.pa = va - K0_BASE;
                    fixed.rd = 1'b1;
                    fixed.wr = 1'b1;
                end
                SEG_K1: begin
                    fixed.pa = va - K1_BASE;
                    fixed.rd = 1'b1;
                    fixed.wr = 1'b1;
                end
                default: need_tlb = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vseg_fault_class.sv
module vseg_fault_class
    import vseg_pkg::*;
(
    input  logic            adr_err,
    input  logic            need_tlb,
    input  logic            is_store,
    input  tlb_res_t        tres,
    input  logic [VA_W-1:0] tlb_pa,
    input  xlate_t          fixed,
    output xlate_t          xl,
    output logic            fault,
    output exc_e            exc,
    output logic            refill
);
    always_comb begin
        xl     = '0;
        fault  = 1'b0;
        exc    = EXC_NONE;
        refill = 1'b0;
        if (adr_err) begin
            fault = 1'b1;
            exc   = pick_exc(is_store, EXC_ADEL, EXC_ADES);
        end else if (need_tlb) begin
            if (!tres.hit) begin
                fault  = 1'b1;
                refill = 1'b1;
                exc    = pick_exc(is_store, EXC_TLBL, EXC_TLBS);
            end else if (!tres.valid) begin
                fault  = 1'b1;
                exc    = pick_exc(is_store, EXC_TLBL, EXC_TLBS);
            end else if (is_store && !tres.dirty) begin
                fault  = 1'b1;
                exc    = EXC_MOD;
            end else begin
                xl.pa  = tlb_pa;
                xl.rd  = 1'b1;
                xl.wr  = tres.dirty;
            end
        end else begin
            xl = fixed;
        end
    end
endmodule

// File: rtl/vseg_capture.sv
module vseg_capture
    import vseg_pkg::*;
#(
    parameter int ASID_W    = 8,
    parameter int PTEBASE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [VA_W-1:0]      va,
    input  logic [ASID_W-1:0]    asid,
    input  logic [PTEBASE_W-1:0] ptebase,
    output logic [VA_W-1:0]      badva,
    output logic [VA_W-1:0]      context_w,
    output logic [VA_W-1:0]      entryhi
);
    localparam int EHI_PAD = PAGE_SH - ASID_W;

    logic [VA_W-1:0] ctx_next;
    logic [VA_W-1:0] ehi_next;

    always_comb begin
        ctx_next = {ptebase, va[VA_W-1:PAIR_SH], {CTX_PAD{1'b0}}};
        ehi_next = {va[VA_W-1:PAGE_SH], {EHI_PAD{1'b0}}, asid};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            badva     <= '0;
            context_w <= '0;
            entryhi   <= '0;
        end else if (fire) begin
            badva     <= va;
            context_w <= ctx_next;
            entryhi   <= ehi_next;
        end
    end
endmodule

// File: rtl/vseg_xlate_unit.sv
module vseg_xlate_unit
    import vseg_pkg::*;
#(
    parameter int ASID_W    = 8,
    parameter int PTEBASE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          va_i,
    input  logic                 is_store_i,
    input  logic                 user_mode_i,
    input  logic                 err_level_i,
    input  logic                 tlb_hit_i,
    input  logic                 tlb_valid_i,
    input  logic                 tlb_dirty_i,
    input  logic [31:0]          tlb_pa_i,
    input  logic                 cap_en_i,
    input  logic [ASID_W-1:0]    asid_i,
    input  logic [PTEBASE_W-1:0] ptebase_i,
    output logic                 tlb_req_o,
    output logic [31:0]          pa_o,
    output logic                 perm_rd_o,
    output logic                 perm_wr_o,
    output logic                 fault_o,
    output logic [2:0]           exc_o,
    output logic                 refill_o,
    output logic [31:0]          badva_o,
    output logic [31:0]          context_o,
    output logic [31:0]          entryhi_o
);
    seg_e     seg;
    logic     adr_err;
    logic     need_tlb;
    xlate_t   fixed;
    xlate_t   xl;
    exc_e     exc;
    logic     fault;
    logic     refill;
    tlb_res_t tres;

    assign tres = '{hit: tlb_hit_i, valid: tlb_valid_i, dirty: tlb_dirty_i};

    vseg_decode u_dec (
        .va        (va_i),
        .user_mode (user_mode_i),
        .err_level (err_level_i),
        .seg       (seg),
        .adr_err   (adr_err),
        .need_tlb  (need_tlb),
        .fixed     (fixed)
    );

    vseg_fault_class u_cls (
        .adr_err  (adr_err),
        .need_tlb (need_tlb),
        .is_store (is_store_i),
        .tres     (tres),
        .tlb_pa   (tlb_pa_i),
        .fixed    (fixed),
        .xl       (xl),
        .fault    (fault),
        .exc      (exc),
        .refill   (refill)
    );

    vseg_capture #(
        .ASID_W    (ASID_W),
        .PTEBASE_W (PTEBASE_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .fire      (fault && cap_en_i),
        .va        (va_i),
        .asid      (asid_i),
        .ptebase   (ptebase_i),
        .badva     (badva_o),
        .context_w (context_o),
        .entryhi   (entryhi_o)
    );

    assign tlb_req_o = need_tlb;
    assign pa_o      = xl.pa;
    assign perm_rd_o = xl.rd;
    assign perm_wr_o = xl.wr;
    assign fault_o   = fault;
    assign exc_o     = exc;
    assign refill_o  = refill;
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] va_i,
    input logic        is_store_i,
    input logic        user_mode_i,
    input logic        err_level_i,
    input logic        cap_en_i,
    input logic        tlb_req_o,
    input logic [31:0] pa_o,
    input logic        fault_o,
    input logic [2:0]  exc_o,
    input logic        refill_o,
    input logic [31:0] badva_o
);
    a_r1_user_kernel: assert property (@(posedge clk) disable iff (rst)
        (user_mode_i && va_i[31]) |->
            (fault_o && !tlb_req_o && (exc_o == (is_store_i ? 3'd2 : 3'd1))));

    a_r2_erl_bypass: assert property (@(posedge clk) disable iff (rst)
        (!va_i[31] && err_level_i) |-> (!fault_o && pa_o == va_i));

    a_r4_kseg0_offset: assert property (@(posedge clk) disable iff (rst)
        (!user_mode_i && va_i[31:29] == 3'b100) |->
            (pa_o == {3'b000, va_i[28:0]}));

    a_r7_refill_kind: assert property (@(posedge clk) disable iff (rst)
        refill_o |-> (fault_o && (exc_o == 3'd3 || exc_o == 3'd4)));

    a_r9_mod_store: assert property (@(posedge clk) disable iff (rst)
        (exc_o == 3'd5) |-> (is_store_i && tlb_req_o));

    a_r10_capture: assert property (@(posedge clk) disable iff (rst)
        (fault_o && cap_en_i) |=> (badva_o == $past(va_i)));

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !(fault_o && cap_en_i) |=> $stable(badva_o));
endmodule

bind vseg_xlate_unit vseg_xlate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .va_i        (va_i),
    .is_store_i  (is_store_i),
    .user_mode_i (user_mode_i),
    .err_level_i (err_level_i),
    .cap_en_i    (cap_en_i),
    .tlb_req_o   (tlb_req_o),
    .pa_o        (pa_o),
    .fault_o     (fault_o),
    .exc_o       (exc_o),
    .refill_o    (refill_o),
    .badva_o     (badva_o)
);

// File: tb/vseg_xlate_unit_bench.sv
module vseg_xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] va_i = '0;
    logic        is_store_i = 1'b0;
    logic        user_mode_i = 1'b0;
    logic        err_level_i = 1'b0;
    logic        tlb_hit_i = 1'b0;
    logic        tlb_valid_i = 1'b0;
    logic        tlb_dirty_i = 1'b0;
    logic [31:0] tlb_pa_i = '0;
    logic        cap_en_i = 1'b0;
    logic [7:0]  asid_i = '0;
    logic [8:0]  ptebase_i = '0;
    logic        tlb_req_o;
    logic [31:0] pa_o;
    logic        perm_rd_o;
    logic        perm_wr_o;
    logic        fault_o;
    logic [2:0]  exc_o;
    logic        refill_o;
    logic [31:0] badva_o;
    logic [31:0] context_o;
    logic [31:0] entryhi_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vseg_xlate_unit u_vseg_xlate_unit (
        .clk(clk), .rst(rst), .va_i(va_i), .is_store_i(is_store_i),
        .user_mode_i(user_mode_i), .err_level_i(err_level_i),
        .tlb_hit_i(tlb_hit_i), .tlb_valid_i(tlb_valid_i),
        .tlb_dirty_i(tlb_dirty_i), .tlb_pa_i(tlb_pa_i), .cap_en_i(cap_en_i),
        .asid_i(asid_i), .ptebase_i(ptebase_i), .tlb_req_o(tlb_req_o),
        .pa_o(pa_o), .perm_rd_o(perm_rd_o), .perm_wr_o(perm_wr_o),
        .fault_o(fault_o), .exc_o(exc_o), .refill_o(refill_o),
        .badva_o(badva_o), .context_o(context_o), .entryhi_o(entryhi_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s va=%h actual=%h expected=%h", req, what, va_i, act, exp);
        end
    endtask

    logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] e_pa;
        logic e_rd, e_wr, e_flt, e_ref, e_req;
        logic [2:0] e_exc;
        string rq;
        int vec = 0;

        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12", "badva reset", badva_o, 32'h0);
        chk("R12", "context reset", context_o, 32'h0);
        chk("R12", "entryhi reset", entryhi_o, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int reg_i = 0; reg_i < 8; reg_i++) begin
            for (int lo = 0; lo < 3; lo++) begin
                for (int ctl = 0; ctl < 128; ctl++) begin
                    @(negedge clk);
                    va_i = {reg_i[2:0], (lo == 0) ? 29'h0 :
                           (lo == 1) ? 29'h1FFF_FFFF : (29'h0ABC_D123 ^ {ctl[6:0], 22'h0})};
                    is_store_i  = ctl[0];
                    user_mode_i = ctl[1];
                    err_level_i = ctl[2];
                    tlb_hit_i   = ctl[3];
                    tlb_valid_i = ctl[4];
                    tlb_dirty_i = ctl[5];
                    cap_en_i    = ctl[6];
                    tlb_pa_i    = 32'h1234_5000 + 32'(vec * 17);
                    asid_i      = 8'(vec * 7 + 3);
                    ptebase_i   = 9'(vec * 13 + 5);
                    vec++;

                    // independent reference model
                    e_pa = 0; e_rd = 0; e_wr = 0; e_flt = 0; e_ref = 0; e_req = 0; e_exc = 0;
                    if (user_mode_i && va_i >= 32'h8000_0000) begin
                        e_flt = 1; e_exc = is_store_i ? 3'd2 : 3'd1; rq = "R1";
                    end else if (va_i < 32'h8000_0000 && err_level_i) begin
                        e_pa = va_i; e_rd = 1; e_wr = 1; rq = "R2";
                    end else if (va_i >= 32'h8000_0000 && va_i < 32'hA000_0000) begin
                        e_pa = va_i - 32'h8000_0000; e_rd = 1; e_wr = 1; rq = "R4";
                    end else if (va_i >= 32'hA000_0000 && va_i < 32'hC000_0000) begin
                        e_pa = va_i - 32'hA000_0000; e_rd = 1; e_wr = 1; rq = "R5";
                    end else begin
                        e_req = 1;
                        rq = (va_i < 32'h8000_0000) ? "R3" : "R6";
                        if (!tlb_hit_i) begin
                            e_flt = 1; e_ref = 1; e_exc = is_store_i ? 3'd4 : 3'd3; rq = {rq, "/R7"};
                        end else if (!tlb_valid_i) begin
                            e_flt = 1; e_exc = is_store_i ? 3'd4 : 3'd3; rq = {rq, "/R8"};
                        end else if (is_store_i && !tlb_dirty_i) begin
                            e_flt = 1; e_exc = 3'd5; rq = {rq, "/R9"};
                        end else begin
                            e_pa = tlb_pa_i; e_rd = 1; e_wr = tlb_dirty_i; rq = {rq, "/R9"};
                        end
                    end

                    #1;
                    chk(rq, "tlb_req", 32'(tlb_req_o), 32'(e_req));
                    chk(rq, "pa", pa_o, e_pa);
                    chk(rq, "perm", {30'h0, perm_rd_o, perm_wr_o}, {30'h0, e_rd, e_wr});
                    chk(rq, "fault", 32'(fault_o), 32'(e_flt));
                    chk(rq, "exc", 32'(exc_o), 32'(e_exc));
                    chk(rq, "refill", 32'(refill_o), 32'(e_ref));

                    if (e_flt && cap_en_i) begin
                        m_bad = va_i;
                        m_ctx = {ptebase_i, va_i[31:13], 4'b0000};
                        m_ehi = {va_i[31:12], 4'b0000, asid_i};
                    end
                    @(posedge clk);
                    #1;
                    rq = (e_flt && cap_en_i) ? "R10/R11" : "R12";
                    chk(rq, "badva", badva_o, m_bad);
                    chk(rq, "context", context_o, m_ctx);
                    chk(rq, "entryhi", entryhi_o, m_ehi);
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule